// File: doc/BRIEF.md
# Battery-Backed Byte Memory Control Front End

This block puts a byte-wide static memory behind an asynchronous, active-low pin interface: a chip select, a write strobe and an output-enable strobe. The outputs are a data byte and a pad-driver enable. A supervisor input, `wp_i`, locks the array during a power fail. The block runs on a sampling clock. Every pin passes through a two-stage synchroniser. Each analog timing figure becomes a parameterised cycle count.

The block decodes each cycle as a read, a write, standby or locked. A write window is bounded by the control edges. Stored data reaches the pads only once the access delay for the current address and strobes has run out. A falling write strobe ends a read after a bounded hold. After a write, a recovery interval must pass before the next write window can open.

Top module: `nvsram_ctrl`

## Requirements
- R1: The address is `ADDR_W` bits wide (default 17). The array holds 2^`MEM_AW` bytes (default 1024), indexed by address bits `MEM_AW-1:0`. Higher address bits select the same locations.
- R2: With chip select low, write strobe high and output enable low, `data_oe_o` rises exactly `ACC_CYC+2` rising clock edges (default 5) after the last change of address, chip select or output enable. `data_o` then carries the stored byte. After an address change, `data_oe_o` stays low for those same edges.
- R3: With output enable high, `data_oe_o` stays low during reads.
- R4: With chip select high, `data_oe_o` is low and no write takes place, whatever the other controls do.
- R5: A write window opens when chip select and write strobe are both low. It closes when the first of them returns high. At the close, the byte on `data_i` is stored. Closing by chip select works the same as closing by write strobe.
- R6: Suppose the drivers are on and the write strobe falls. The drivers stay on for `ODW_CYC` cycles after the synchronised fall (default 2). They go low `ODW_CYC+2` edges after the pin falls.
- R7: After a write closes, the write strobe must stay high for `REC_CYC` consecutive cycles (default 4) before another window can open. A window attempted earlier stores nothing.
- R8: While `wp_i` is high, `data_oe_o` is low and no write can open or commit.
- R9: A write window that is open when `wp_i` rises is discarded, even after the protection drops.
- R10: The location written is the address present when the window opened. Later address changes within the window are ignored.
- R11: After reset, `data_oe_o` and `data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output enable, active low |
| wp_i | input | 1 | Power-fail write protect, active high |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Write data from the pad |
| data_o | output | 8 | Read data to the pad |
| data_oe_o | output | 1 | Pad driver enable |

## Verification
The bench checks the exact edge on which the drivers turn on, both after select and after an address change. A timer that failed to restart would drive stale data early. It checks the bounded hold after a falling write strobe, which catches drivers that end one cycle early or late. It probes the recovery interval with a second write strobe that comes too soon; a design that ignores recovery would overwrite the first byte. Protection raised in the middle of a write is tested, as is an address moved within a window. A design that committed the discarded window or followed the new address would leave the wrong byte behind.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY,
    MODE_READ,
    MODE_WRITE,
    MODE_LOCKED
  } mode_e;

  function automatic mode_e decode_mode(input logic ce_n, input logic we_n, input logic wp);
    if (wp)         return MODE_LOCKED;
    else if (ce_n)  return MODE_STANDBY;
    else if (!we_n) return MODE_WRITE;
    else            return MODE_READ;
  endfunction
endpackage

// File: rtl/nvsram_sync.sv
module nvsram_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/nvsram_wr_ctrl.sv
module nvsram_wr_ctrl
  import nvsram_pkg::*;
#(
  parameter int AW      = 10,
  parameter int DW      = 8,
  parameter int REC_CYC = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  mode_e         mode_i,
  input  logic          ce_n_i,
  input  logic          we_n_i,
  input  logic          wp_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          commit_o,
  output logic [AW-1:0] commit_addr_o,
  output logic [DW-1:0] commit_data_o
);
  localparam int RW = $clog2(REC_CYC + 1);
  localparam logic [RW-1:0] REC_LOAD = RW'(REC_CYC);

  logic          win_q;
  logic [AW-1:0] addr_q;
  logic [RW-1:0] rec_q;
  logic          open_ok, close, abort;

  assign open_ok = (mode_i == MODE_WRITE) && (rec_q == '0);
  assign close   = win_q && !wp_i && (ce_n_i || we_n_i);
  assign abort   = win_q && wp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= 1'b0;
      addr_q <= '0;
      rec_q  <= '0;
    end else begin
      if (!win_q) begin
        if (open_ok) begin
          win_q  <= 1'b1;
          addr_q <= addr_i;
        end
      end else if (close || abort) begin
        win_q <= 1'b0;
      end
      // recovery: strobe must stay high for REC_CYC consecutive cycles
      if (close)             rec_q <= REC_LOAD;
      else if (rec_q != '0)  rec_q <= we_n_i ? rec_q - 1'b1 : REC_LOAD;
    end
  end

  assign commit_o      = close;
  assign commit_addr_o = addr_q;
  assign commit_data_o = data_i;

  // R8
  lock_no_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |-> !commit_o);
  // R7
  rec_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !win_q);
  // R5
  open_from_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_q) |-> $past(!ce_n_i && !we_n_i));
endmodule

// File: rtl/nvsram_rd_path.sv
module nvsram_rd_path
  import nvsram_pkg::*;
#(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int ACC_CYC = 3,
  parameter int ODW_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  mode_e         mode_i,
  input  logic          ce_n_i,
  input  logic          we_n_i,
  input  logic          oe_n_i,
  input  logic          wp_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] data_o,
  output logic          oe_o
);
  localparam int CW = $clog2(ACC_CYC + 1);
  localparam logic [CW-1:0] ACC_MAX = CW'(ACC_CYC);

  logic [CW-1:0] acc_q;
  logic [AW-1:0] addr_prev_q;
  logic [DW-1:0] data_q;
  logic          drv_q, we_prev_q;
  logic          drive_req, addr_chg, main_on, hold_on;

  assign drive_req = (mode_i == MODE_READ) && !oe_n_i;
  assign addr_chg  = addr_i != addr_prev_q;
  assign main_on   = drive_req && (acc_q == ACC_MAX) && !addr_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      addr_prev_q <= '0;
      data_q      <= '0;
      drv_q       <= 1'b0;
      we_prev_q   <= 1'b1;
    end else begin
      addr_prev_q <= addr_i;
      data_q      <= rdata_i;
      drv_q       <= oe_o;
      we_prev_q   <= we_n_i;
      // this cycle counts as the first of the access delay
      if (!drive_req)             acc_q <= '0;
      else if (addr_chg)          acc_q <= CW'(1);
      else if (acc_q != ACC_MAX)  acc_q <= acc_q + 1'b1;
    end
  end

  generate
    if (ODW_CYC > 0) begin : g_hold
      localparam int HW = $clog2(ODW_CYC + 1);
      logic [HW-1:0] hold_q;
      logic          cont_ok, fell;
      assign cont_ok = (mode_i == MODE_WRITE) && !oe_n_i;
      assign fell    = we_prev_q && !we_n_i && drv_q;
      assign hold_on = cont_ok && (fell || hold_q != '0);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              hold_q <= '0;
        else if (!cont_ok)        hold_q <= '0;
        else if (fell)            hold_q <= HW'(ODW_CYC - 1);
        else if (hold_q != '0)    hold_q <= hold_q - 1'b1;
      end
    end else begin : g_no_hold
      assign hold_on = 1'b0;
    end
  endgenerate

  assign oe_o   = main_on || hold_on;
  assign data_o = data_q;

  // R4
  standby_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n_i |-> !oe_o);
  // R8
  wp_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |-> !oe_o);
  // R2
  drive_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !drv_q) |-> (we_n_i && !oe_n_i));
  // R6
  we_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !we_n_i) |-> drv_q);
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvsram_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int MEM_AW  = 10,
  parameter int ACC_CYC = 3,
  parameter int ODW_CYC = 2,
  parameter int REC_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              wp_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o
);
  localparam int DW    = 8;
  localparam int DEPTH = 1 << MEM_AW;
  localparam int BW    = ADDR_W + DW;

  logic [3:0]        ctrl_s;
  logic [BW-1:0]     bus_s;
  logic              ce_s, we_s, oe_s, wp_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DW-1:0]     wdata_s, rdata, commit_data;
  logic [MEM_AW-1:0] commit_addr;
  logic              commit;
  mode_e             mode;
  logic [DW-1:0]     mem_q [DEPTH];

  // controls reset to inactive, protection reset to locked
  nvsram_sync #(.W(4), .RST_VAL(4'b1111)) u_sync_ctrl (
    .clk_i, .rst_ni, .d_i({wp_i, oe_ni, we_ni, ce_ni}), .q_o(ctrl_s)
  );
  nvsram_sync #(.W(BW), .RST_VAL('0)) u_sync_bus (
    .clk_i, .rst_ni, .d_i({addr_i, data_i}), .q_o(bus_s)
  );

  assign {wp_s, oe_s, we_s, ce_s} = ctrl_s;
  assign {addr_s, wdata_s}        = bus_s;
  assign mode                     = decode_mode(ce_s, we_s, wp_s);

  nvsram_wr_ctrl #(.AW(MEM_AW), .DW(DW), .REC_CYC(REC_CYC)) u_wr (
    .clk_i, .rst_ni,
    .mode_i        (mode),
    .ce_n_i        (ce_s),
    .we_n_i        (we_s),
    .wp_i          (wp_s),
    .addr_i        (addr_s[MEM_AW-1:0]),
    .data_i        (wdata_s),
    .commit_o      (commit),
    .commit_addr_o (commit_addr),
    .commit_data_o (commit_data)
  );

  always_ff @(posedge clk_i) begin
    if (commit) mem_q[commit_addr] <= commit_data;
  end

  assign rdata = mem_q[addr_s[MEM_AW-1:0]];

  nvsram_rd_path #(.AW(ADDR_W), .DW(DW), .ACC_CYC(ACC_CYC), .ODW_CYC(ODW_CYC)) u_rd (
    .clk_i, .rst_ni,
    .mode_i  (mode),
    .ce_n_i  (ce_s),
    .we_n_i  (we_s),
    .oe_n_i  (oe_s),
    .wp_i    (wp_s),
    .addr_i  (addr_s),
    .rdata_i (rdata),
    .data_o  (data_o),
    .oe_o    (data_oe_o)
  );
endmodule

// File: tb/sim_nvsram_ctrl.sv
`timescale 1ns/1ps
module sim_nvsram_ctrl;
  localparam int ACC = 3;
  localparam int ODW = 2;
  localparam int REC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wp = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        doe;
  int          checks = 0, failures = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  nvsram_ctrl #(.ADDR_W(17), .MEM_AW(10), .ACC_CYC(ACC), .ODW_CYC(ODW), .REC_CYC(REC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n), .wp_i(wp),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    nwait(4);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    nwait(1); we_n = 1'b0;
    nwait(4); we_n = 1'b1;
    nwait(3); ce_n = 1'b1;
    nwait(REC + 3);
  endtask

  task automatic do_read(input logic [16:0] a, output logic [7:0] d, output logic on);
    @(negedge clk);
    addr = a; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    nwait(ACC + 2);
    on = doe; d = dout;
  endtask

  task automatic t_reset();
    chk("R11 oe after reset", doe, 0);
    chk("R11 data after reset", dout, 0);
  endtask

  task automatic t_read_timing();
    logic [7:0] d; logic on;
    do_write(17'h00012, 8'hA5);
    do_write(17'h00013, 8'h3C);
    @(negedge clk);
    addr = 17'h00012; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    nwait(ACC + 1);
    chk("R2 drivers off one edge early", doe, 0);
    nwait(1);
    chk("R2 drivers on at ACC+2", doe, 1);
    chk("R2 read data", dout, 8'hA5);
    // address change restarts the access delay
    addr = 17'h00013;
    nwait(ACC + 1);
    chk("R2 off after address change", doe, 0);
    nwait(1);
    chk("R2 on after new access", doe, 1);
    chk("R2 new read data", dout, 8'h3C);
    idle();
    do_read(17'h00012, d, on);
    chk("R2 repeat read", {on, d}, {1'b1, 8'hA5});
    idle();
  endtask

  task automatic t_oe_high();
    @(negedge clk);
    addr = 17'h00012; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    nwait(ACC + 5);
    chk("R3 oe high keeps drivers off", doe, 0);
    idle();
  endtask

  task automatic t_standby();
    logic [7:0] d; logic on;
    do_write(17'h00020, 8'h11);
    @(negedge clk);
    addr = 17'h00020; din = 8'hEE; ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b0;
    nwait(8);
    chk("R4 standby drivers off", doe, 0);
    we_n = 1'b1;
    idle();
    do_read(17'h00020, d, on);
    chk("R4 standby no write", d, 8'h11);
    idle();
  endtask

  task automatic t_alias();
    logic [7:0] d; logic on;
    do_write(17'h10021, 8'h77);
    do_read(17'h00021, d, on);
    chk("R1 upper address bits alias", {on, d}, {1'b1, 8'h77});
    idle();
  endtask

  task automatic t_we_disable();
    logic [7:0] d; logic on;
    do_write(17'h00030, 8'h01);
    do_read(17'h00030, d, on);
    chk("R6 drivers on before strobe", on, 1);
    din = 8'h5A; we_n = 1'b0;
    nwait(ODW + 1);
    chk("R6 drivers held", doe, 1);
    nwait(1);
    chk("R6 drivers released", doe, 0);
    nwait(2);
    ce_n = 1'b1;          // close by chip select
    nwait(3);
    we_n = 1'b1; oe_n = 1'b1;
    nwait(REC + 3);
    do_read(17'h00030, d, on);
    chk("R5 write closed by chip select", d, 8'h5A);
    idle();
  endtask

  task automatic t_recovery();
    logic [7:0] d; logic on;
    @(negedge clk);
    addr = 17'h00040; din = 8'h61; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    nwait(1); we_n = 1'b0;
    nwait(4); we_n = 1'b1;
    nwait(1); din = 8'h62;
    nwait(1); we_n = 1'b0;   // too soon
    nwait(4); we_n = 1'b1;
    nwait(3); ce_n = 1'b1;
    nwait(REC + 3);
    do_read(17'h00040, d, on);
    chk("R7 early strobe dropped", d, 8'h61);
    idle();
    do_write(17'h00040, 8'h63);
    do_read(17'h00040, d, on);
    chk("R7 write after recovery", d, 8'h63);
    idle();
  endtask

  task automatic t_wp();
    logic [7:0] d; logic on;
    do_read(17'h00012, d, on);
    chk("R8 read before lock", on, 1);
    wp = 1'b1;
    nwait(3);
    chk("R8 lock drops drivers", doe, 0);
    idle();
    do_write(17'h00012, 8'hFF);
    wp = 1'b0;
    idle();
    do_read(17'h00012, d, on);
    chk("R8 locked write ignored", d, 8'hA5);
    idle();
  endtask

  task automatic t_wp_abort();
    logic [7:0] d; logic on;
    do_write(17'h00050, 8'h44);
    @(negedge clk);
    addr = 17'h00050; din = 8'h99; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    nwait(4); wp = 1'b1;
    nwait(4); we_n = 1'b1;
    nwait(3); ce_n = 1'b1;
    nwait(2); wp = 1'b0;
    nwait(REC + 3);
    do_read(17'h00050, d, on);
    chk("R9 aborted window discarded", d, 8'h44);
    idle();
  endtask

  task automatic t_addr_latch();
    logic [7:0] d; logic on;
    do_write(17'h00060, 8'h10);
    do_write(17'h00061, 8'h20);
    @(negedge clk);
    addr = 17'h00060; din = 8'h30; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    nwait(1); we_n = 1'b0;
    nwait(4); addr = 17'h00061;
    nwait(4); we_n = 1'b1;
    nwait(3); ce_n = 1'b1;
    nwait(REC + 3);
    do_read(17'h00060, d, on);
    chk("R10 write at opening address", d, 8'h30);
    idle();
    do_read(17'h00061, d, on);
    chk("R10 moved address untouched", d, 8'h20);
    idle();
  endtask

  initial begin
    nwait(3);
    t_reset();
    rst_n = 1'b1;
    nwait(4);
    t_read_timing();
    t_oe_high();
    t_standby();
    t_alias();
    t_we_disable();
    t_recovery();
    t_wp();
    t_wp_abort();
    t_addr_latch();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule